// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block produces bit timing for one direction of an asynchronous serial link. The timing is derived from a reference tick: a one-cycle enable that marks each period of a slower internal reference. An 11-bit rate word selects the division. Its top bit switches in a fixed divide-by-8 prescaler. Its low ten bits give a reload divisor N. The divider fires once per half bit, and a two-phase stage turns every second firing into a full-bit strobe. The bit rate is therefore Fref / (2 × N × (8 when prescaled, else 1)). For example, with a 1 MHz reference, word 0x034 gives close to 9600 bit/s, 0x0D0 close to 2400 bit/s and 0x4D0 close to 300 bit/s.

A serial port places one instance in front of its transmitter and another in front of its receiver, so that the two rates can be set independently. The phase stage is a three-state machine. IDLE is entered at reset and emits nothing. A load moves the machine to FIRST_HALF from any state. The transition FIRST_HALF→SECOND_HALF happens on a divider expiry and emits a half-bit strobe. The transition SECOND_HALF→FIRST_HALF happens on a divider expiry and emits both a half-bit strobe and a full-bit strobe.

Top module: `rate_gen`

## Requirements
- R1: After reset both strobes are low, and they stay low, whatever the reference tick does, until the first load.
- R2: With bit 10 of the rate word clear, a half-bit strobe occurs once every N reference ticks, counted from the load. N is bits 9..0 of the rate word.
- R3: With bit 10 set, a half-bit strobe occurs once every 8×N reference ticks.
- R4: A divisor field of 0 acts as N = 1024.
- R5: The full-bit strobe is high exactly on every second half-bit strobe after a load, and only together with a half-bit strobe.
- R6: A load captures the rate word and restarts the prescaler, the divider and the phase from their initial state. A reference tick in the load cycle is not counted. No strobe is high in the cycle after a load.
- R7: Each strobe is high in the clock cycle that follows the cycle in which the completing reference tick was high. Each strobe lasts that one cycle per completing tick.
- R8: Cycles with the reference tick low do not advance any count and are followed by no strobe.
- R9: N = 1 without prescaling gives a half-bit strobe after every reference tick, and a full-bit strobe after every second tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference tick enable, one cycle per reference period |
| rate_word | input | 11 | Bit 10: prescaler enable; bits 9..0: divisor N (0 means 1024) |
| load | input | 1 | Capture rate_word and restart all stages |
| half_stb | output | 1 | One-cycle strobe at each half-bit boundary |
| full_stb | output | 1 | One-cycle strobe at each full-bit boundary |

## Verification
The hardest case to reach is a divisor field of zero. With the prescaler off, that case needs 1024 reference ticks per half bit. With the prescaler on, it needs thousands of ticks. The bench holds the tick high continuously during those phases, so the wrap to 1024 is reached within a few thousand cycles. A restart in mid-interval is reached by issuing loads a few ticks after the previous load, partway through a prescaler or divider count. Sparse and irregular tick patterns show that idle cycles do not advance the counts. A behavioural tick-count model checks both strobes on every clock.

// File: rtl/rate_pkg.sv
package rate_pkg;
    typedef enum logic [1:0] {
        PH_IDLE        = 2'd0,
        PH_FIRST_HALF  = 2'd1,
        PH_SECOND_HALF = 2'd2
    } phase_t;
endpackage

// File: rtl/rate_prescale.sv
module rate_prescale #(
    parameter int PRE_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic pre_en,
    input  logic tick_in,
    output logic tick_out
);
    generate
        if (PRE_DIV > 1) begin : g_div
            localparam int CW = $clog2(PRE_DIV);
            localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (restart) begin
                    cnt <= '0;
                end else if (tick_in && pre_en) begin
                    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                end
            end

            assign tick_out = tick_in && !restart && (!pre_en || cnt == LAST);
        end else begin : g_pass
            assign tick_out = tick_in && !restart;
        end
    endgenerate
endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick_in,
    input  logic [DIV_W-1:0] divisor,
    output logic             expire
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] term;

    // A zero divisor wraps to all ones, so the divider counts 2**DIV_W ticks.
    assign term   = divisor - 1'b1;
    assign expire = tick_in && !restart && (cnt == term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick_in) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rate_phase.sv
module rate_phase
    import rate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  logic   expire,
    output phase_t phase,
    output logic   half_stb,
    output logic   full_stb
);
    phase_t nxt;

    always_comb begin
        nxt = phase;
        if (load) begin
            nxt = PH_FIRST_HALF;
        end else begin
            unique case (phase)
                PH_IDLE:        nxt = PH_IDLE;
                PH_FIRST_HALF:  if (expire) nxt = PH_SECOND_HALF;
                PH_SECOND_HALF: if (expire) nxt = PH_FIRST_HALF;
                default:        nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_stb <= 1'b0;
            full_stb <= 1'b0;
        end else begin
            half_stb <= expire && !load && (phase != PH_IDLE);
            full_stb <= expire && !load && (phase == PH_SECOND_HALF);
        end
    end
endmodule

// File: rtl/rate_gen.sv
module rate_gen
    import rate_pkg::*;
#(
    parameter int DIV_W   = 10,
    parameter int PRE_DIV = 8,
    localparam int RATE_W = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [RATE_W-1:0] rate_word,
    input  logic              load,
    output logic              half_stb,
    output logic              full_stb
);
    logic [RATE_W-1:0] rate_q;
    phase_t            phase;
    logic              running;
    logic              stage_tick;
    logic              expire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rate_q <= '0;
        else if (load) rate_q <= rate_word;
    end

    assign running = (phase != PH_IDLE);

    rate_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .pre_en  (rate_q[RATE_W-1]),
        .tick_in (ref_tick && running),
        .tick_out(stage_tick)
    );

    rate_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .tick_in (stage_tick),
        .divisor (rate_q[DIV_W-1:0]),
        .expire  (expire)
    );

    rate_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .expire  (expire),
        .phase   (phase),
        .half_stb(half_stb),
        .full_stb(full_stb)
    );
endmodule

// File: rtl/rate_gen_chk.sv
module rate_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic load,
    input logic ref_tick,
    input logic half_stb,
    input logic full_stb
);
    logic seen_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    seen_load <= 1'b0;
        else if (load) seen_load <= 1'b1;
    end

    a_r1_quiet_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_load |-> (!half_stb && !full_stb));

    a_r5_full_with_half: assert property (@(posedge clk) disable iff (!rst_n)
        full_stb |-> half_stb);

    a_r5_no_back_to_back_full: assert property (@(posedge clk) disable iff (!rst_n)
        full_stb |=> !full_stb);

    a_r6_load_silences: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!half_stb && !full_stb));

    a_r8_idle_tick_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> !half_stb);
endmodule

bind rate_gen rate_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .ref_tick(ref_tick),
    .half_stb(half_stb),
    .full_stb(full_stb)
);

// File: tb/sim_rate_gen.sv
module sim_rate_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [10:0] rate_word = '0;
    logic        load = 1'b0;
    logic        half_stb;
    logic        full_stb;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // reference model state
    bit  m_run = 0;
    bit  m_pre = 0;
    int  m_n = 1;
    int  m_r = 0;
    int  m_s = 0;
    int  m_h = 0;
    bit  exp_half = 0;
    bit  exp_full = 0;

    always #10 clk = ~clk;

    rate_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .rate_word(rate_word),
        .load     (load),
        .half_stb (half_stb),
        .full_stb (full_stb)
    );

    always @(posedge clk) begin
        cyc++;
        exp_half = 0;
        exp_full = 0;
        if (!rst_n) begin
            m_run = 0;
        end else if (load) begin
            m_run = 1;
            m_pre = rate_word[10];
            m_n   = (rate_word[9:0] == 0) ? 1024 : int'(rate_word[9:0]);
            m_r = 0; m_s = 0; m_h = 0;
        end else if (m_run && ref_tick) begin
            m_r++;
            if (!m_pre || (m_r % 8 == 0)) begin
                m_s++;
                if (m_s % m_n == 0) begin
                    m_h++;
                    exp_half = 1;
                    exp_full = (m_h % 2 == 0);
                end
            end
        end
    end

    always @(negedge clk) begin
        n_checks++;
        if (half_stb !== exp_half) begin
            n_errors++;
            $display("FAIL %s half_stb cycle %0d: actual=%b expected=%b", cur_req, cyc, half_stb, exp_half);
        end
        n_checks++;
        if (full_stb !== exp_full) begin
            n_errors++;
            $display("FAIL R5 full_stb cycle %0d: actual=%b expected=%b", cyc, full_stb, exp_full);
        end
    end

    task automatic do_load(input logic [10:0] w);
        @(negedge clk);
        rate_word = w;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // tick high on cycles where i % period == 0
    task automatic run_ticks(input int cycles, input int period);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            ref_tick = (i % period == 0);
        end
    endtask

    initial begin
        // R1: reset and pre-load quiet, ticks toggling
        cur_req = "R1";
        ref_tick = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run_ticks(20, 1);

        // R2: N=5 without prescale, continuous ticks
        cur_req = "R2";
        do_load(11'h005);
        run_ticks(60, 1);

        // R8: N=3 with sparse and irregular ticks
        cur_req = "R8";
        do_load(11'h003);
        run_ticks(90, 3);
        run_ticks(70, 7);

        // R3: prescale on, N=2 then 0x0D0 with prescale
        cur_req = "R3";
        do_load(11'h402);
        run_ticks(120, 1);
        run_ticks(200, 2);
        do_load(11'h4D0);
        run_ticks(3400, 1);

        // R9: N=1 no prescale
        cur_req = "R9";
        do_load(11'h001);
        run_ticks(30, 1);
        run_ticks(30, 2);

        // R4: divisor zero means 1024, without and with prescale
        cur_req = "R4";
        do_load(11'h000);
        run_ticks(2100, 1);
        do_load(11'h400);
        run_ticks(16500, 1);

        // R6: restarts mid-interval, tick held high through the load cycle
        cur_req = "R6";
        ref_tick = 1'b1;
        do_load(11'h006);
        run_ticks(4, 1);
        do_load(11'h004);
        run_ticks(6, 1);
        do_load(11'h403);
        run_ticks(13, 1);
        do_load(11'h402);
        run_ticks(60, 1);

        // R7: latency and one-cycle width with an isolated completing tick
        cur_req = "R7";
        do_load(11'h002);
        run_ticks(40, 5);
        run_ticks(10, 1);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(20 * 190000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule